// File: doc/BRIEF.md
# Integer-Domain Frequency and Phase Error Detector for a Counter-Based Coarse Loop

This block is the digital front end of a coarse frequency and phase acquisition loop that has no time-to-digital converter. An oscillator edge counter, running in its own clock domain, is sampled once per retimed reference tick. The block differentiates those samples into a per-tick frequency code. It turns the fractional part of the frequency control word into a stream of integer carries with a first-order accumulator modulator. It subtracts the two to get a frequency error that uses integer bits only.

The error feeds one of two integrators, chosen by a mode input. In frequency-lock mode a frequency accumulator gathers the error for fast pull-in. In phase-lock mode a phase accumulator integrates it into a phase error. The selected accumulator goes through a proportional-integral filter with programmable shifts. Its clamped output is the oscillator control code. The residue of the modulator is exported every tick so that a delay-line stage can shift the reference edge by the matching fraction of an oscillator period.

When the counter is sampled on the oscillator edge chosen by the modulator, the measured and reference codes land on the same integer grid. The error is then exactly zero in steady state, even for a fractional control word.

Top module: `cntfrac_err_det`

## Requirements
- R1: The error outputs (`freq_err`, `dsm_carry`, `dsm_residue`, `fll_acc`, `phase_err`) change only on a clock edge where `tick` is high. `err_valid` is high for exactly the cycle after each such edge, except after the priming tick.
- R2: The first tick after reset only captures the count. It raises no `err_valid`, leaves the modulator state unchanged, and produces no error.
- R3: The measured frequency code is the current count minus the count at the previous tick, taken modulo 4096. A count that wraps past 4095 gives the true positive difference.
- R4: On every counted tick the modulator forms residue + `fcw_frac` in 17 bits. Bit 16 of that sum becomes `dsm_carry` (1 when the sum is 65536 or more). The low 16 bits become the new `dsm_residue`. The reference code is `fcw_int` + `dsm_carry`.
- R5: `freq_err` is the signed value of reference code minus measured code. With a control word of 2.25 and the counter sampled on the modulator's chosen edges, `freq_err` and `phase_err` are 0 on every tick.
- R6: With `phase_mode`=0 (frequency lock), `fll_acc` adds `freq_err` on each counted tick and `phase_err` is forced to 0. With `phase_mode`=1 (phase lock), `phase_err` adds `freq_err` and `fll_acc` holds its value. Both accumulators saturate at their signed 24-bit limits.
- R7: One cycle after `err_valid`, `ctrl_valid` pulses and the filter updates. Let x be `phase_err` if phase lock was selected at that tick, else `fll_acc`. The integral I becomes clamp(I + (x >>> `ki_shift`), -2048, 2048). `ctrl_code` becomes 2048 + (x >>> `kp_shift`) + I.
- R8: `ctrl_code` is clamped to the range 16 to 4079.
- R9: After reset, all error outputs, both accumulators and both strobes are 0, and `ctrl_code` is 2048.
- R10: For a control word of 2.25, if the count is instead taken on the oscillator edge after the reference edge, the error keeps alternating. `phase_err` then steps between 0 and -1 and never settles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digital loop clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe for each retimed reference edge |
| osc_count | input | 12 | Oscillator edge count sampled at the tick |
| fcw_int | input | 8 | Integer part of the frequency control word |
| fcw_frac | input | 16 | Fractional part of the frequency control word |
| phase_mode | input | 1 | 0 = frequency lock, 1 = phase lock |
| kp_shift | input | 4 | Right shift of the proportional term |
| ki_shift | input | 4 | Right shift of the integral increment |
| freq_err | output | 14 | Signed integer frequency error |
| err_valid | output | 1 | Pulse after each counted tick |
| dsm_carry | output | 1 | Integer carry D[k] of the modulator |
| dsm_residue | output | 16 | Modulator residue for delay compensation |
| fll_acc | output | 24 | Signed frequency-lock accumulator |
| phase_err | output | 24 | Signed phase error accumulator |
| ctrl_code | output | 12 | Oscillator control code |
| ctrl_valid | output | 1 | Pulse after each filter update |

## Verification
The bench runs a behavioural oscillator that is sampled on the modulator's chosen edges at a control word of 2.25. This pattern shows whether the reference and measured grids line up exactly, which gives a zero error. The same oscillator is then shifted half a period and sampled on the next edge, which tells a stair-shaped phase error apart from a settled one. Offset oscillator rates in both directions drive the filter into each clamp. An odd fraction with a count starting near 4090 exercises counter wrap under sparse and back-to-back ticks.

// File: rtl/ffd_pkg.sv
package ffd_pkg;
  typedef enum logic {
    MODE_FREQ  = 1'b0,
    MODE_PHASE = 1'b1
  } lock_mode_e;
endpackage

// File: rtl/ffd_diff.sv
module ffd_diff #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] fv,
  output logic             primed,
  output logic             step
);
  logic [CNT_W-1:0] prev_q;

  // modular difference handles wrap of the counter
  assign fv   = cnt - prev_q;
  assign step = tick & primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      primed <= 1'b0;
    end else if (tick) begin
      prev_q <= cnt;
      primed <= 1'b1;
    end
  end

  // R3: a counted tick always keeps the primed state
  assert_primed_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    primed |=> primed);
endmodule

// File: rtl/ffd_sdm.sv
module ffd_sdm #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry_nx,
  output logic              carry_o,
  output logic [FRAC_W-1:0] qe_o
);
  logic [FRAC_W:0] sum;

  assign sum      = {1'b0, qe_o} + {1'b0, frac};
  assign carry_nx = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_o <= 1'b0;
      qe_o    <= '0;
    end else if (step) begin
      carry_o <= sum[FRAC_W];
      qe_o    <= sum[FRAC_W-1:0];
    end
  end

  // R4: a carry out is exactly a residue that wrapped below its old value
  assert_carry_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && frac != '0) |=> (carry_o == (qe_o < $past(qe_o))));
endmodule

// File: rtl/ffd_loopfilt.sv
module ffd_loopfilt #(
  parameter int ACC_W    = 24,
  parameter int CTRL_W   = 12,
  parameter int SHIFT_W  = 4,
  parameter int CTRL_MIN = 16,
  parameter int CTRL_MAX = 4079,
  parameter int I_LIM    = 2048,
  localparam int SW      = ACC_W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [ACC_W-1:0]  x,
  input  logic [SHIFT_W-1:0]       kp,
  input  logic [SHIFT_W-1:0]       ki,
  output logic [CTRL_W-1:0]        ctrl_o,
  output logic                     valid_o
);
  localparam int CTRL_MID = 1 << (CTRL_W - 1);
  localparam logic signed [SW-1:0] I_HI  = SW'(I_LIM);
  localparam logic signed [SW-1:0] I_LO  = -SW'(I_LIM);
  localparam logic signed [SW-1:0] C_HI  = SW'(CTRL_MAX);
  localparam logic signed [SW-1:0] C_LO  = SW'(CTRL_MIN);
  localparam logic signed [SW-1:0] C_MID = SW'(CTRL_MID);

  logic signed [ACC_W-1:0] i_q;
  logic signed [ACC_W-1:0] p_term, i_inc;
  logic signed [SW-1:0]    i_sum, i_nx, c_sum;

  assign p_term = x >>> kp;
  assign i_inc  = x >>> ki;

  always_comb begin
    i_sum = SW'(i_q) + SW'(i_inc);
    if (i_sum > I_HI)      i_nx = I_HI;
    else if (i_sum < I_LO) i_nx = I_LO;
    else                   i_nx = i_sum;
    c_sum = C_MID + SW'(p_term) + i_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_q     <= '0;
      ctrl_o  <= CTRL_W'(CTRL_MID);
      valid_o <= 1'b0;
    end else begin
      valid_o <= en;
      if (en) begin
        i_q <= i_nx[ACC_W-1:0];
        if (c_sum > C_HI)      ctrl_o <= CTRL_W'(CTRL_MAX);
        else if (c_sum < C_LO) ctrl_o <= CTRL_W'(CTRL_MIN);
        else                   ctrl_o <= c_sum[CTRL_W-1:0];
      end
    end
  end

  // R8: control code never leaves its limits
  assert_ctrl_bounds_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (ctrl_o >= CTRL_W'(CTRL_MIN) && ctrl_o <= CTRL_W'(CTRL_MAX)));
  // R7: integral state stays inside its anti-windup window
  assert_int_window_R7: assert property (@(posedge clk) disable iff (rst)
    en |=> (SW'(i_q) <= I_HI && SW'(i_q) >= I_LO));
endmodule

// File: rtl/cntfrac_err_det.sv
module cntfrac_err_det #(
  parameter int CNT_W    = 12,
  parameter int INT_W    = 8,
  parameter int FRAC_W   = 16,
  parameter int ACC_W    = 24,
  parameter int CTRL_W   = 12,
  parameter int SHIFT_W  = 4,
  parameter int CTRL_MIN = 16,
  parameter int CTRL_MAX = 4079,
  parameter int I_LIM    = 2048,
  localparam int ERR_W   = CNT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [CNT_W-1:0]        osc_count,
  input  logic [INT_W-1:0]        fcw_int,
  input  logic [FRAC_W-1:0]       fcw_frac,
  input  logic                    phase_mode,
  input  logic [SHIFT_W-1:0]      kp_shift,
  input  logic [SHIFT_W-1:0]      ki_shift,
  output logic signed [ERR_W-1:0] freq_err,
  output logic                    err_valid,
  output logic                    dsm_carry,
  output logic [FRAC_W-1:0]       dsm_residue,
  output logic signed [ACC_W-1:0] fll_acc,
  output logic signed [ACC_W-1:0] phase_err,
  output logic [CTRL_W-1:0]       ctrl_code,
  output logic                    ctrl_valid
);
  import ffd_pkg::*;

  localparam int AW = ACC_W + 1;
  localparam logic signed [AW-1:0] A_HI = AW'((64'sd1 <<< (ACC_W - 1)) - 1);
  localparam logic signed [AW-1:0] A_LO = -AW'(64'sd1 <<< (ACC_W - 1));

  logic [CNT_W-1:0]        fv;
  logic                    primed, step, carry_nx;
  logic signed [ERR_W-1:0] fe_nx;
  logic signed [AW-1:0]    fll_sum, ph_sum, fll_nx, ph_nx;
  lock_mode_e              mode_in, mode_q;

  assign mode_in = lock_mode_e'(phase_mode);

  ffd_diff #(.CNT_W(CNT_W)) u_diff (
    .clk(clk), .rst(rst), .tick(tick), .cnt(osc_count),
    .fv(fv), .primed(primed), .step(step)
  );

  ffd_sdm #(.FRAC_W(FRAC_W)) u_sdm (
    .clk(clk), .rst(rst), .step(step), .frac(fcw_frac),
    .carry_nx(carry_nx), .carry_o(dsm_carry), .qe_o(dsm_residue)
  );

  always_comb begin
    fe_nx   = $signed(ERR_W'(fcw_int) + ERR_W'(carry_nx)) - $signed(ERR_W'(fv));
    fll_sum = AW'(fll_acc) + AW'(fe_nx);
    ph_sum  = AW'(phase_err) + AW'(fe_nx);
    if (fll_sum > A_HI)      fll_nx = A_HI;
    else if (fll_sum < A_LO) fll_nx = A_LO;
    else                     fll_nx = fll_sum;
    if (ph_sum > A_HI)       ph_nx = A_HI;
    else if (ph_sum < A_LO)  ph_nx = A_LO;
    else                     ph_nx = ph_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_err  <= '0;
      fll_acc   <= '0;
      phase_err <= '0;
      mode_q    <= MODE_FREQ;
      err_valid <= 1'b0;
    end else begin
      err_valid <= step;
      if (step) begin
        freq_err <= fe_nx;
        mode_q   <= mode_in;
        if (mode_in == MODE_PHASE) begin
          phase_err <= ph_nx[ACC_W-1:0];
        end else begin
          fll_acc   <= fll_nx[ACC_W-1:0];
          phase_err <= '0;
        end
      end
    end
  end

  ffd_loopfilt #(
    .ACC_W(ACC_W), .CTRL_W(CTRL_W), .SHIFT_W(SHIFT_W),
    .CTRL_MIN(CTRL_MIN), .CTRL_MAX(CTRL_MAX), .I_LIM(I_LIM)
  ) u_lf (
    .clk(clk), .rst(rst), .en(err_valid),
    .x((mode_q == MODE_PHASE) ? phase_err : fll_acc),
    .kp(kp_shift), .ki(ki_shift),
    .ctrl_o(ctrl_code), .valid_o(ctrl_valid)
  );

  // R1: no tick, no change on the error side
  assert_quiet_without_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(freq_err) && $stable(dsm_residue) && $stable(dsm_carry)
               && $stable(fll_acc) && $stable(phase_err) && !err_valid));
  // R2: priming tick yields no valid error
  assert_prime_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !primed) |=> (!err_valid && $stable(dsm_residue)));
  // R6: frequency lock keeps the phase path cleared
  assert_phase_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !phase_mode) |=> (phase_err == '0));
  // R6: phase lock freezes the frequency accumulator
  assert_fll_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (step && phase_mode) |=> $stable(fll_acc));
  // R7: filter strobe trails the error strobe by one cycle
  assert_ctrl_follows_R7: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> ctrl_valid);
  assert_ctrl_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> !ctrl_valid);
endmodule

// File: tb/sim_cntfrac_err_det.sv
module sim_cntfrac_err_det;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [11:0] osc_count = '0;
  logic [7:0]  fcw_int = '0;
  logic [15:0] fcw_frac = '0;
  logic        phase_mode = 1'b0;
  logic [3:0]  kp_shift = '0;
  logic [3:0]  ki_shift = '0;
  logic signed [13:0] freq_err;
  logic        err_valid, dsm_carry, ctrl_valid;
  logic [15:0] dsm_residue;
  logic signed [23:0] fll_acc, phase_err;
  logic [11:0] ctrl_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cntfrac_err_det u0 (
    .clk(clk), .rst(rst), .tick(tick), .osc_count(osc_count),
    .fcw_int(fcw_int), .fcw_frac(fcw_frac), .phase_mode(phase_mode),
    .kp_shift(kp_shift), .ki_shift(ki_shift), .freq_err(freq_err),
    .err_valid(err_valid), .dsm_carry(dsm_carry), .dsm_residue(dsm_residue),
    .fll_acc(fll_acc), .phase_err(phase_err), .ctrl_code(ctrl_code),
    .ctrl_valid(ctrl_valid)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  longint m_prev, m_acc, m_fe, m_fll, m_ph, m_i, m_ctrl;
  bit     m_primed, m_carry, m_mode, m_ev, m_cv;
  localparam longint A_MAX = (64'sd1 <<< 23) - 1;
  localparam longint A_MIN = -(64'sd1 <<< 23);

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev = 0; m_acc = 0; m_fe = 0; m_fll = 0; m_ph = 0; m_i = 0;
      m_ctrl = 2048; m_primed = 0; m_carry = 0; m_mode = 0; m_ev = 0; m_cv = 0;
    end else begin
      longint x, fv, s;
      m_cv = m_ev;
      if (m_ev) begin
        x = m_mode ? m_ph : m_fll;
        m_i = clampl(m_i + (x >>> ki_shift), -2048, 2048);
        m_ctrl = clampl(2048 + (x >>> kp_shift) + m_i, 16, 4079);
      end
      m_ev = 0;
      if (tick) begin
        if (!m_primed) begin
          m_primed = 1;
          m_prev = osc_count;
        end else begin
          fv = (longint'(osc_count) - m_prev) & 4095;
          m_prev = osc_count;
          s = m_acc + fcw_frac;
          m_carry = (s >= 65536);
          m_acc = s % 65536;
          m_fe = longint'(fcw_int) + m_carry - fv;
          m_mode = phase_mode;
          if (phase_mode) m_ph = clampl(m_ph + m_fe, A_MIN, A_MAX);
          else begin
            m_fll = clampl(m_fll + m_fe, A_MIN, A_MAX);
            m_ph = 0;
          end
          m_ev = 1;
        end
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5", "freq_err", freq_err, m_fe);
      check("R4", "dsm_carry", dsm_carry, m_carry);
      check("R4", "dsm_residue", dsm_residue, m_acc);
      check("R6", "fll_acc", fll_acc, m_fll);
      check("R6", "phase_err", phase_err, m_ph);
      check("R1", "err_valid", err_valid, m_ev);
      check("R7", "ctrl_valid", ctrl_valid, m_cv);
      check("R7", "ctrl_code", ctrl_code, m_ctrl);
    end
  end

  // oscillator: position in 1/65536 of a period
  longint osc_q, rate_q, base_cnt;

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tick = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_tick(int gap);
    @(negedge clk);
    tick = 1'b1;
    osc_count = 12'((base_cnt + (osc_q >>> 16)) & 4095);
    osc_q += rate_q;
    @(negedge clk);
    tick = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  initial begin : watchdog
    #1_600_000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nz;
    longint mx;
    fcw_int = 8'd2; fcw_frac = 16'h4000;  // 2.25
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", "reset ctrl_code", ctrl_code, 2048);
    check("R9", "reset fll_acc", fll_acc, 0);
    check("R9", "reset phase_err", phase_err, 0);
    check("R9", "reset strobes", {err_valid, ctrl_valid}, 0);
    check("R9", "reset residue", dsm_residue, 0);

    // aligned sampling, 2.25, frequency then phase lock
    kp_shift = 4'd1; ki_shift = 4'd3; phase_mode = 1'b0;
    osc_q = 0; rate_q = 2 * 65536 + 16384; base_cnt = 100;
    do_tick(0);
    check("R2", "priming err_valid", err_valid, 0);
    check("R2", "priming residue", dsm_residue, 0);
    for (int k = 0; k < 20; k++) do_tick(2);
    check("R5", "aligned fll_acc zero", fll_acc, 0);
    phase_mode = 1'b1;
    for (int k = 0; k < 20; k++) begin
      do_tick(1);
      check("R5", "aligned freq_err zero", freq_err, 0);
      check("R5", "aligned phase_err zero", phase_err, 0);
    end
    check("R7", "aligned ctrl_code mid", ctrl_code, 2048);

    // half-period offset sampling: stair phase error
    do_reset();
    osc_q = 32768; base_cnt = 7; phase_mode = 1'b1;
    nz = 0; mx = 0;
    do_tick(1);
    for (int k = 0; k < 24; k++) begin
      do_tick(1);
      if (phase_err != 0) nz++;
      if (phase_err > mx) mx = phase_err;
      if (-phase_err > mx) mx = -phase_err;
    end
    check("R10", "stair steps seen", (nz > 0), 1);
    check("R10", "stair bounded to 1", (mx <= 1), 1);

    // oscillator fast: clamp low; count wraps through 4095
    do_reset();
    phase_mode = 1'b0; kp_shift = 4'd0; ki_shift = 4'd0;
    osc_q = 0; rate_q = 5 * 65536 + 16384; base_cnt = 4090;
    for (int k = 0; k < 42; k++) do_tick(k % 3);
    check("R8", "low clamp", ctrl_code, 16);

    // oscillator slow: clamp high
    do_reset();
    osc_q = 0; rate_q = 16384; base_cnt = 0;
    for (int k = 0; k < 52; k++) do_tick(0);
    @(negedge clk);
    check("R8", "high clamp", ctrl_code, 4079);

    // odd fraction with wrap, back-to-back and spaced ticks (R3)
    do_reset();
    fcw_int = 8'd7; fcw_frac = 16'h5A3C; kp_shift = 4'd2; ki_shift = 4'd5;
    osc_q = 12345; rate_q = 7 * 65536 + 16'h5A3C + 900; base_cnt = 4080;
    for (int k = 0; k < 30; k++) do_tick((k % 4 == 0) ? 3 : 0);
    phase_mode = 1'b1;
    for (int k = 0; k < 30; k++) do_tick(k % 2);
    @(negedge clk); @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule